// File: doc/BRIEF.md
# Serial Flash I/O Protocol Selector

This block keeps the volatile enhanced configuration byte of a serial flash controller. From it the block decides which bus protocol the controller runs: extended single-line, dual I/O or quad I/O. It also decides whether the shared hold/reset pin keeps its hold/reset meaning. The command decoder upstream gives the block two things. It reports the data byte of a configuration write once all eight bits of that byte are in. It also passes the chip-select line through. The block applies a new byte only when chip select is released after the byte has been completed. Selections that end before the byte is complete leave the configuration as it was.

Two bits of the byte are active low and select the protocol. The quad bit has priority over the dual bit. The hold-enable bit is volatile. On every power-on reset it is reloaded from the copy held in the nonvolatile configuration image. All other bits are stored and read back as written.

Top module: `flash_proto_sel`

## Requirements
- R1: While `por_n` is low the byte is loaded with all ones, except that bit 4 takes the value of `nv_hold_en`. After reset the outputs show `mode` = 00 and `hold_en` = `nv_hold_en`.
- R2: When bit 7 of the byte is 1 and bit 6 is 0, `mode` is 01 (dual I/O).
- R3: When bit 7 of the byte is 0, `mode` is 10 (quad I/O), whatever the value of bit 6.
- R4: When bits 7 and 6 are both 1, `mode` is 00 (extended single-line). This includes the case where bit 6 is set back to 1 after dual was selected.
- R5: A byte captured while `cs_n` is low is written at the first clock edge where `cs_n` is sampled high. `cfg_q`, `mode` and `hold_en` show the new value right after that edge.
- R6: If `cs_n` is released before `byte_done` was seen during the selection, the configuration does not change.
- R7: A `byte_done` pulse while `cs_n` is high is ignored.
- R8: Only the first completed byte of a selection is kept. Later `byte_done` pulses in the same selection are ignored.
- R9: `hold_en` equals bit 4 of the byte. A 0 in that bit disables hold/reset and a 1 enables it again.
- R10: Bits 5 and 3 to 0 read back on `cfg_q` exactly as written and have no effect on `mode`.
- R11: `mode` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| cs_n | input | 1 | Chip select, active low |
| byte_done | input | 1 | Configuration-write data byte complete (one-cycle pulse) |
| byte_data | input | 8 | Data byte of the configuration write |
| nv_hold_en | input | 1 | Hold-enable bit of the nonvolatile configuration image |
| cfg_q | output | 8 | Current configuration byte |
| mode | output | 2 | Protocol: 00 extended, 01 dual, 10 quad |
| hold_en | output | 1 | Hold/reset function on the shared pin enabled |

## Verification
A wrong pending flag or captured byte can show up in two ways. `cfg_q` may change on a release of chip select where it should stay the same, or it may keep its old value where it should change. Either fault is visible right after the clock edge that first samples `cs_n` high. A wrong stored byte or a wrong decode shows on `mode` and `hold_en` in that same cycle. For this reason the reference model is compared with all three outputs on every clock. The checks run through every mix of bits 7 and 6, through partial and out-of-selection strobes, and through resets with both values of the nonvolatile bit.

// File: rtl/flash_proto_pkg.sv
package flash_proto_pkg;
   typedef enum logic [1:0] {
      PROTO_EXT  = 2'b00,
      PROTO_DUAL = 2'b01,
      PROTO_QUAD = 2'b10
   } proto_t;
endpackage

// File: rtl/fps_capture.sv
module fps_capture #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         cs_n,
   input  logic         byte_done,
   input  logic [W-1:0] byte_data,
   output logic         commit,
   output logic [W-1:0] commit_data
);
   logic         held_q;
   logic [W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         held_q <= 1'b0;
         data_q <= '0;
      end else if (cs_n) begin
         held_q <= 1'b0;
      end else if (byte_done && !held_q) begin
         held_q <= 1'b1;
         data_q <= byte_data;
      end
   end

   assign commit      = cs_n && held_q;
   assign commit_data = data_q;
endmodule

// File: rtl/fps_store.sv
module fps_store #(
   parameter int         W         = 8,
   parameter int         HOLD_BIT  = 4,
   parameter logic [W-1:0] RESET_VAL = '1
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         nv_hold_en,
   input  logic         commit,
   input  logic [W-1:0] commit_data,
   output logic [W-1:0] cfg_q
);
   logic [W-1:0] boot_val;

   always_comb begin
      boot_val           = RESET_VAL;
      boot_val[HOLD_BIT] = nv_hold_en;
   end

   always_ff @(posedge clk) begin
      if (!por_n)      cfg_q <= boot_val;
      else if (commit) cfg_q <= commit_data;
   end
endmodule

// File: rtl/fps_decode.sv
module fps_decode
   import flash_proto_pkg::*;
#(
   parameter int W        = 8,
   parameter int QUAD_BIT = 7,
   parameter int DUAL_BIT = 6,
   parameter bit REG_OUT  = 1'b0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] cfg,
   output proto_t       mode
);
   proto_t next_mode;

   always_comb begin
      if (!cfg[QUAD_BIT])      next_mode = PROTO_QUAD;
      else if (!cfg[DUAL_BIT]) next_mode = PROTO_DUAL;
      else                     next_mode = PROTO_EXT;
   end

   generate
      if (REG_OUT) begin : g_reg
         proto_t mode_q;
         always_ff @(posedge clk) begin
            if (!por_n) mode_q <= PROTO_EXT;
            else        mode_q <= next_mode;
         end
         assign mode = mode_q;
      end else begin : g_comb
         assign mode = next_mode;
      end
   endgenerate
endmodule

// File: rtl/flash_proto_sel.sv
module flash_proto_sel
   import flash_proto_pkg::*;
#(
   parameter int         CFG_W     = 8,
   parameter int         QUAD_BIT  = 7,
   parameter int         DUAL_BIT  = 6,
   parameter int         HOLD_BIT  = 4,
   parameter logic [CFG_W-1:0] RESET_VAL = '1,
   parameter bit         REG_OUT   = 1'b0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             cs_n,
   input  logic             byte_done,
   input  logic [CFG_W-1:0] byte_data,
   input  logic             nv_hold_en,
   output logic [CFG_W-1:0] cfg_q,
   output logic [1:0]       mode,
   output logic             hold_en
);
   localparam int MAX_BIT = CFG_W - 1;

   generate
      if (QUAD_BIT > MAX_BIT || DUAL_BIT > MAX_BIT || HOLD_BIT > MAX_BIT) begin : g_bad_idx
         $error("flash_proto_sel: control bit index outside configuration width");
      end
      if (QUAD_BIT == DUAL_BIT || QUAD_BIT == HOLD_BIT || DUAL_BIT == HOLD_BIT) begin : g_bad_overlap
         $error("flash_proto_sel: control bits must be distinct");
      end
   endgenerate

   logic             commit;
   logic [CFG_W-1:0] commit_data;
   proto_t           mode_e;

   fps_capture #(.W(CFG_W)) u_capture (
      .clk(clk), .por_n(por_n), .cs_n(cs_n),
      .byte_done(byte_done), .byte_data(byte_data),
      .commit(commit), .commit_data(commit_data)
   );

   fps_store #(.W(CFG_W), .HOLD_BIT(HOLD_BIT), .RESET_VAL(RESET_VAL)) u_store (
      .clk(clk), .por_n(por_n), .nv_hold_en(nv_hold_en),
      .commit(commit), .commit_data(commit_data), .cfg_q(cfg_q)
   );

   fps_decode #(.W(CFG_W), .QUAD_BIT(QUAD_BIT), .DUAL_BIT(DUAL_BIT), .REG_OUT(REG_OUT)) u_decode (
      .clk(clk), .por_n(por_n), .cfg(cfg_q), .mode(mode_e)
   );

   assign mode    = mode_e;
   assign hold_en = cfg_q[HOLD_BIT];
endmodule

// File: rtl/flash_proto_sel_chk.sv
module flash_proto_sel_chk #(
   parameter int CFG_W    = 8,
   parameter int QUAD_BIT = 7,
   parameter int DUAL_BIT = 6,
   parameter bit REG_OUT  = 1'b0
) (
   input logic             clk,
   input logic             por_n,
   input logic             cs_n,
   input logic             nv_hold_en,
   input logic [CFG_W-1:0] cfg_q,
   input logic [1:0]       mode,
   input logic             hold_en
);
   assert_boot_state_R1: assert property (@(posedge clk) disable iff (!por_n)
      $past(!por_n) |-> (hold_en == $past(nv_hold_en) && mode == 2'b00));

   assert_no_write_without_release_R6: assert property (@(posedge clk) disable iff (!por_n)
      !(cs_n && !$past(cs_n)) |=> $stable(cfg_q));

   assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!por_n)
      $onehot0(mode));

   generate
      if (!REG_OUT) begin : g_comb_chk
         assert_quad_priority_R3: assert property (@(posedge clk) disable iff (!por_n)
            !cfg_q[QUAD_BIT] |-> mode == 2'b10);
         assert_dual_select_R2: assert property (@(posedge clk) disable iff (!por_n)
            (cfg_q[QUAD_BIT] && !cfg_q[DUAL_BIT]) |-> mode == 2'b01);
      end
   endgenerate
endmodule

bind flash_proto_sel flash_proto_sel_chk #(
   .CFG_W(CFG_W), .QUAD_BIT(QUAD_BIT), .DUAL_BIT(DUAL_BIT), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .por_n(por_n), .cs_n(cs_n), .nv_hold_en(nv_hold_en),
   .cfg_q(cfg_q), .mode(mode), .hold_en(hold_en)
);

// File: tb/flash_proto_sel_test.sv
module flash_proto_sel_test;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       byte_done = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic       nv_hold_en = 1'b0;
   logic [7:0] cfg_q;
   logic [1:0] mode;
   logic       hold_en;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [7:0] m_cfg = 8'hFF;
   logic [7:0] m_pdata = 8'h00;
   bit         m_pend = 1'b0;

   always #4 clk = ~clk;

   flash_proto_sel uut (
      .clk(clk), .por_n(por_n), .cs_n(cs_n), .byte_done(byte_done),
      .byte_data(byte_data), .nv_hold_en(nv_hold_en),
      .cfg_q(cfg_q), .mode(mode), .hold_en(hold_en)
   );

   // behavioural reference, one update per rising edge
   always @(posedge clk) begin
      if (!por_n) begin
         m_cfg = 8'hFF;
         m_cfg[4] = nv_hold_en;
         m_pend = 1'b0;
      end else if (cs_n) begin
         if (m_pend) m_cfg = m_pdata;
         m_pend = 1'b0;
      end else if (byte_done && !m_pend) begin
         m_pend = 1'b1;
         m_pdata = byte_data;
      end
   end

   function automatic logic [1:0] exp_mode(logic [7:0] c);
      if (!c[7]) return 2'b10;
      if (!c[6]) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag);
      @(negedge clk);
      check(tag, "cfg_q", {24'h0, cfg_q}, {24'h0, m_cfg});
      check(tag, "mode", {30'h0, mode}, {30'h0, exp_mode(m_cfg)});
      check(tag, "hold_en", {31'h0, hold_en}, {31'h0, m_cfg[4]});
   endtask

   task automatic write_cfg(logic [7:0] d, string tag);
      cs_n = 1'b0; step(tag);
      byte_done = 1'b1; byte_data = d; step(tag);
      byte_done = 1'b0; step(tag);
      cs_n = 1'b1; step(tag);
      step(tag);
   endtask

   initial begin
      // R1: reset with nonvolatile hold bit cleared
      nv_hold_en = 1'b0;
      step("R1"); step("R1");
      check("R1", "boot cfg", {24'h0, cfg_q}, 32'hEF);
      check("R1", "boot hold", {31'h0, hold_en}, 32'h0);
      por_n = 1'b1; step("R1");
      check("R1", "boot mode", {30'h0, mode}, 32'h0);

      // R2: dual
      write_cfg(8'hBF, "R2");
      check("R2", "dual", {30'h0, mode}, 32'h1);
      // R4: back to extended
      write_cfg(8'hFF, "R4");
      check("R4", "ext", {30'h0, mode}, 32'h0);
      // R3: quad alone and with dual bit
      write_cfg(8'h7F, "R3");
      check("R3", "quad b6=1", {30'h0, mode}, 32'h2);
      write_cfg(8'h3F, "R3");
      check("R3", "quad b6=0", {30'h0, mode}, 32'h2);

      // R5: exact commit edge
      cs_n = 1'b0; byte_done = 1'b1; byte_data = 8'hBF; step("R5");
      byte_done = 1'b0; step("R5");
      check("R5", "held before release", {24'h0, cfg_q}, 32'h3F);
      cs_n = 1'b1; step("R5");
      check("R5", "after release", {24'h0, cfg_q}, 32'hBF);
      check("R5", "mode after release", {30'h0, mode}, 32'h1);

      // R6: partial selection
      cs_n = 1'b0; step("R6"); step("R6");
      cs_n = 1'b1; step("R6"); step("R6");
      check("R6", "partial ignored", {24'h0, cfg_q}, 32'hBF);

      // R7: strobe while deselected
      byte_done = 1'b1; byte_data = 8'h00; step("R7");
      byte_done = 1'b0; step("R7"); step("R7");
      check("R7", "deselected strobe", {24'h0, cfg_q}, 32'hBF);

      // R8: second byte in the same selection
      cs_n = 1'b0; byte_done = 1'b1; byte_data = 8'hFF; step("R8");
      byte_data = 8'h00; step("R8");
      byte_done = 1'b0; cs_n = 1'b1; step("R8"); step("R8");
      check("R8", "first byte kept", {24'h0, cfg_q}, 32'hFF);

      // R9: hold disable and re-enable
      write_cfg(8'hEF, "R9");
      check("R9", "hold off", {31'h0, hold_en}, 32'h0);
      write_cfg(8'hFF, "R9");
      check("R9", "hold on", {31'h0, hold_en}, 32'h1);

      // R10: other bits read back, mode unaffected
      write_cfg(8'hD0, "R10");
      check("R10", "readback", {24'h0, cfg_q}, 32'hD0);
      check("R10", "mode ext", {30'h0, mode}, 32'h0);
      write_cfg(8'hE5, "R10");
      check("R10", "readback2", {24'h0, cfg_q}, 32'hE5);

      // R11: sweep every byte, mode stays legal
      for (int i = 0; i < 256; i += 7) begin
         write_cfg(i[7:0], "R11");
         check("R11", "mode legal", {31'h0, mode == 2'b11}, 32'h0);
      end

      // R1: reset with nonvolatile hold bit set after a hold-off write
      write_cfg(8'h2F, "R1");
      nv_hold_en = 1'b1; por_n = 1'b0; step("R1"); step("R1");
      por_n = 1'b1; step("R1");
      check("R1", "reboot cfg", {24'h0, cfg_q}, 32'hFF);
      check("R1", "reboot hold", {31'h0, hold_en}, 32'h1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule